// File: doc/BRIEF.md
# Bus-Programmed Configuration Register Bank with Standard Presets

This block is a two-wire (I2C) slave that holds the configuration bytes of a multistandard broadcast receiver. It drives them as parallel outputs to the datapath. It also returns a few read-only status bytes and a fixed identity byte to the bus. The device address is a fixed base value modified by two select pins, so up to four of these banks can share one bus. A write gives a register index followed by any number of data bytes. A read sets the index with a write, then issues a repeated START. Both directions step the index by one after every byte.

Register 00h selects the broadcast standard, one bit per standard. When a value with exactly one bit set is written there, a small sequencer copies that standard's recommended settings into the dependent control registers, one register per clock. Software therefore needs only a single write to set up a standard. The individual registers can still be written by hand afterwards. A control register carries a standby bit and a self-restoring soft-reset bit. Writing 0 to the soft-reset bit sends a fixed-length reset pulse to the processing logic and leaves every register value as it was.

SCL and SDA are oversampled on the system clock. That clock must run at least eight times faster than the bus clock, which is at most 400 kHz. SDA is open-drain: the block only ever pulls it low.

Top module: `cfg_regbank_i2c`

## Requirements
- R1: The 7-bit device address equals 42h XOR (addr_sel_i shifted left by one), so the default pins give write byte 84h and read byte 85h. The slave pulls SDA low in the ninth clock only for its own address and for the bytes that follow it. A transfer to any other address is not acknowledged and changes nothing.
- R2: In a write, the byte after the address is the register index. Each following data byte is stored at the current index, and the index then advances by one.
- R3: A read after a repeated START returns the registers from the current index, MSB first. The index advances by one per byte, until the master answers a byte with a NACK.
- R4: Register 00h is the standard selector, and it resets to 01h. Bits 0 to 7 select, in order: M/N, B, G/H, I, D/K, L, L-accent and FM radio. Its value appears on cfg_o[7:0].
- R5: Writing a value with exactly one bit set (bit s) to 00h while no load is running does two things. It loads register 01h+k with s*16 + 2*k + 1, for k = 0..5, and the registers are loaded one per clock. It also holds preset_busy_o high for exactly 6 clock cycles. A write to 00h that arrives during those cycles is dropped.
- R6: A write to 00h whose value has zero bits set, or more than one bit set, is stored but loads no preset, and preset_busy_o stays low.
- R7: The following registers are read-only, and writes to them are ignored: 08h to 0Bh return status_i bytes 0 to 3, and 0Ch returns the identity 5Ch. Indices 0Dh and above read 00h.
- R8: Writing a byte with bit 0 equal to 0 to control register 07h drives proc_rst_o high for 4 clock cycles. Bit 0 always reads back as 1, and no other register changes.
- R9: Bit 1 of register 07h resets to 0 and drives standby_o directly.
- R10: After reset, registers 01h to 06h hold the M/N preset (01h, 03h, 05h, 07h, 09h, 0Bh) and register 07h reads 01h. cfg_o carries register i on bits [8*i+7 : 8*i] for i = 0..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_oe_o | output | 1 | Pull SDA low when high |
| addr_sel_i | input | 2 | Address select pins |
| status_i | input | 32 | Four read-only status bytes |
| cfg_o | output | 64 | Registers 00h to 07h, byte per register |
| standby_o | output | 1 | Standby request |
| proc_rst_o | output | 1 | Soft reset pulse to the processing logic |
| preset_busy_o | output | 1 | Preset copy in progress |

## Verification
On every cycle, the embedded properties check the following. The slave never pulls SDA while idle. A standard write with one bit set starts a load, and a write with any other bit count never starts one. A standard write during a load leaves the selector unchanged. The index moves on after each stored byte. The soft-reset pulse lasts more than one cycle and leaves the configuration outputs alone.

Only the directed scenarios can show the other behaviours. These are the exact preset values, the busy and reset pulse lengths, and the byte ordering of bursts and reads. They also include the rejection of foreign addresses and of writes to read-only locations, which the scenarios check by reading the data back over the bus.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RXACK,
      ST_TX,
      ST_TXACK
   } bus_st_e;

   typedef enum logic [1:0] {
      BK_ADDR,
      BK_INDEX,
      BK_DATA
   } byte_kind_e;

   // recommended byte for dependent slot k under standard s: s*16 + 2k + 1
   function automatic logic [7:0] preset_byte(input logic [2:0] std, input logic [2:0] slot);
      return {1'b0, std, slot, 1'b1};
   endfunction

endpackage

// File: rtl/cfgbank_sync.sv
module cfgbank_sync #(
   parameter int STAGES = 2,
   parameter bit INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("cfgbank_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic r1;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r1 <= INIT;
            else        r1 <= d;
         end
         assign q = r1;
      end else begin : g_chain
         logic [STAGES-1:0] ch;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch <= {STAGES{INIT}};
            else        ch <= {ch[STAGES-2:0], d};
         end
         assign q = ch[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/cfgbank_i2c_if.sv
module cfgbank_i2c_if
   import cfgbank_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_s,
   input  logic       sda_s,
   input  logic [6:0] dev_addr,
   input  logic [7:0] rd_data,
   output logic [7:0] rd_idx,
   output logic       wr_stb,
   output logic [7:0] wr_idx,
   output logic [7:0] wr_dat,
   output logic       sda_oe
);

   bus_st_e    st;
   byte_kind_e kind;
   logic [7:0] sh;
   logic [7:0] ptr;
   logic [3:0] bcnt;
   logic       rw;
   logic       nack;
   logic       scl_d, sda_d;
   logic       scl_rise, scl_fall, start_c, stop_c;

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
   assign rd_idx   = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         kind   <= BK_ADDR;
         sh     <= '0;
         ptr    <= '0;
         bcnt   <= '0;
         rw     <= 1'b0;
         nack   <= 1'b0;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
         wr_stb <= 1'b0;
         wr_idx <= '0;
         wr_dat <= '0;
         sda_oe <= 1'b0;
      end else begin
         scl_d  <= scl_s;
         sda_d  <= sda_s;
         wr_stb <= 1'b0;
         if (start_c) begin
            st     <= ST_RX;
            kind   <= BK_ADDR;
            bcnt   <= '0;
            sda_oe <= 1'b0;
         end else if (stop_c) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     sh   <= {sh[6:0], sda_s};
                     bcnt <= bcnt + 4'd1;
                  end else if (scl_fall && bcnt == 4'd8) begin
                     bcnt <= '0;
                     case (kind)
                        BK_ADDR: begin
                           if (sh[7:1] == dev_addr) begin
                              rw     <= sh[0];
                              sda_oe <= 1'b1;
                              st     <= ST_RXACK;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        BK_INDEX: begin
                           ptr    <= sh;
                           sda_oe <= 1'b1;
                           st     <= ST_RXACK;
                        end
                        default: begin
                           wr_stb <= 1'b1;
                           wr_idx <= ptr;
                           wr_dat <= sh;
                           ptr    <= ptr + 8'd1;
                           sda_oe <= 1'b1;
                           st     <= ST_RXACK;
                        end
                     endcase
                  end
               end
               ST_RXACK: begin
                  if (scl_fall) begin
                     if (kind == BK_ADDR && rw) begin
                        sh     <= rd_data;
                        ptr    <= ptr + 8'd1;
                        sda_oe <= ~rd_data[7];
                        bcnt   <= '0;
                        st     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        kind   <= (kind == BK_ADDR) ? BK_INDEX : BK_DATA;
                        st     <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bcnt <= bcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bcnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        bcnt   <= '0;
                        st     <= ST_TXACK;
                     end else begin
                        sh     <= {sh[6:0], 1'b0};
                        sda_oe <= ~sh[6];
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) begin
                     nack <= sda_s;
                  end else if (scl_fall) begin
                     if (nack) begin
                        st <= ST_IDLE;
                     end else begin
                        sh     <= rd_data;
                        ptr    <= ptr + 8'd1;
                        sda_oe <= ~rd_data[7];
                        st     <= ST_TX;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R1: an idle slave leaves the line alone
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   // R1: a foreign address is never acknowledged
   a_r1_foreign_nack: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RX && kind == BK_ADDR && scl_fall && bcnt == 4'd8 &&
       !start_c && !stop_c && sh[7:1] != dev_addr) |=> !sda_oe);

   // R2: the index moves on after each stored byte
   a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (rd_idx == wr_idx + 8'd1));

endmodule

// File: rtl/cfgbank_regs.sv
module cfgbank_regs
   import cfgbank_pkg::*;
#(
   parameter int         NUM_DEP  = 6,
   parameter int         NUM_STAT = 4,
   parameter int         SRST_LEN = 4,
   parameter logic [7:0] ID_CODE  = 8'h5C
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_stb,
   input  logic [7:0]                wr_idx,
   input  logic [7:0]                wr_dat,
   input  logic [7:0]                rd_idx,
   input  logic [8*NUM_STAT-1:0]     status_i,
   output logic [7:0]                rd_data,
   output logic [8*(NUM_DEP+2)-1:0]  cfg_o,
   output logic                      standby_o,
   output logic                      proc_rst_o,
   output logic                      busy_o
);

   localparam int NUM_RW    = NUM_DEP + 2;
   localparam int CTRL_IDX  = NUM_DEP + 1;
   localparam int STAT_BASE = NUM_RW;
   localparam int ID_IDX    = STAT_BASE + NUM_STAT;
   localparam int CW        = $clog2(SRST_LEN + 1);

   generate
      if (NUM_DEP < 1 || NUM_DEP > 7) begin : g_bad_dep
         $error("cfgbank_regs: NUM_DEP must lie in 1..7");
      end
      if (NUM_STAT < 1 || ID_IDX > 255) begin : g_bad_map
         $error("cfgbank_regs: register map does not fit the index space");
      end
      if (SRST_LEN < 2) begin : g_bad_srst
         $error("cfgbank_regs: SRST_LEN must be at least 2");
      end
   endgenerate

   logic [7:0]    std_q;
   logic [7:0]    dep_q [NUM_DEP];
   logic          stby_q;
   logic          busy_q;
   logic [2:0]    seq_k, seq_s;
   logic [CW-1:0] srst_cnt;
   logic          std_wr, std_hot;
   logic [2:0]    std_enc;

   assign std_wr  = wr_stb && (wr_idx == 8'd0);
   assign std_hot = ($countones(wr_dat) == 1);

   always_comb begin
      std_enc = '0;
      for (int b = 0; b < 8; b++) begin
         if (wr_dat[b]) std_enc = 3'(b);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         std_q <= 8'h01;
         for (int k = 0; k < NUM_DEP; k++) dep_q[k] <= preset_byte(3'd0, 3'(k));
         stby_q   <= 1'b0;
         busy_q   <= 1'b0;
         seq_k    <= '0;
         seq_s    <= '0;
         srst_cnt <= '0;
      end else begin
         if (srst_cnt != '0) srst_cnt <= srst_cnt - CW'(1);
         if (std_wr && !busy_q) begin
            std_q <= wr_dat;
            if (std_hot) begin
               busy_q <= 1'b1;
               seq_k  <= '0;
               seq_s  <= std_enc;
            end
         end
         for (int k = 0; k < NUM_DEP; k++) begin
            if (wr_stb && wr_idx == 8'(k + 1)) dep_q[k] <= wr_dat;
         end
         if (wr_stb && wr_idx == 8'(CTRL_IDX)) begin
            stby_q <= wr_dat[1];
            if (!wr_dat[0]) srst_cnt <= CW'(SRST_LEN);
         end
         if (busy_q) begin
            for (int k = 0; k < NUM_DEP; k++) begin
               if (seq_k == 3'(k)) dep_q[k] <= preset_byte(seq_s, 3'(k));
            end
            if (seq_k == 3'(NUM_DEP - 1)) busy_q <= 1'b0;
            else                          seq_k  <= seq_k + 3'd1;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_idx == 8'd0) rd_data = std_q;
      for (int k = 0; k < NUM_DEP; k++) begin
         if (rd_idx == 8'(k + 1)) rd_data = dep_q[k];
      end
      if (rd_idx == 8'(CTRL_IDX)) rd_data = {6'b0, stby_q, 1'b1};
      for (int j = 0; j < NUM_STAT; j++) begin
         if (rd_idx == 8'(STAT_BASE + j)) rd_data = status_i[8*j +: 8];
      end
      if (rd_idx == 8'(ID_IDX)) rd_data = ID_CODE;
   end

   assign cfg_o[7:0] = std_q;
   generate
      for (genvar g = 0; g < NUM_DEP; g++) begin : g_dep_out
         assign cfg_o[8*(g+1) +: 8] = dep_q[g];
      end
   endgenerate
   assign cfg_o[8*CTRL_IDX +: 8] = {6'b0, stby_q, 1'b1};

   assign standby_o  = stby_q;
   assign proc_rst_o = (srst_cnt != '0);
   assign busy_o     = busy_q;

   // R5: a one-hot selector write starts the copy
   a_r5_load_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && std_wr && std_hot) |=> busy_q);

   // R5: a selector write during a copy is dropped
   a_r5_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && std_wr) |=> $stable(std_q));

   // R6: any other bit count never starts a copy
   a_r6_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && std_wr && !std_hot) |=> !busy_q);

   // R8: the reset pulse outlasts one cycle
   a_r8_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(proc_rst_o) |=> proc_rst_o);

   // R8: the pulse leaves the configuration alone
   a_r8_regs_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_rst_o && !wr_stb && !busy_q) |=> $stable(cfg_o));

endmodule

// File: rtl/cfg_regbank_i2c.sv
module cfg_regbank_i2c #(
   parameter logic [6:0] BASE_ADDR   = 7'h42,
   parameter int         SYNC_STAGES = 2,
   parameter int         NUM_DEP     = 6,
   parameter int         NUM_STAT    = 4,
   parameter int         SRST_LEN    = 4,
   parameter logic [7:0] ID_CODE     = 8'h5C
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scl_i,
   input  logic                     sda_i,
   output logic                     sda_oe_o,
   input  logic [1:0]               addr_sel_i,
   input  logic [8*NUM_STAT-1:0]    status_i,
   output logic [8*(NUM_DEP+2)-1:0] cfg_o,
   output logic                     standby_o,
   output logic                     proc_rst_o,
   output logic                     preset_busy_o
);

   logic       scl_s, sda_s;
   logic [6:0] dev_addr;
   logic [7:0] rd_idx, rd_data, wr_idx, wr_dat;
   logic       wr_stb;

   assign dev_addr = BASE_ADDR ^ {4'b0, addr_sel_i, 1'b0};

   cfgbank_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));

   cfgbank_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   cfgbank_i2c_if u_if (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .dev_addr(dev_addr), .rd_data(rd_data), .rd_idx(rd_idx),
      .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_dat(wr_dat), .sda_oe(sda_oe_o));

   cfgbank_regs #(
      .NUM_DEP(NUM_DEP), .NUM_STAT(NUM_STAT),
      .SRST_LEN(SRST_LEN), .ID_CODE(ID_CODE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
      .wr_dat(wr_dat), .rd_idx(rd_idx), .status_i(status_i),
      .rd_data(rd_data), .cfg_o(cfg_o), .standby_o(standby_o),
      .proc_rst_o(proc_rst_o), .busy_o(preset_busy_o));

endmodule

// File: tb/cfg_regbank_i2c_test.sv
module cfg_regbank_i2c_test;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_low = 1'b0;
   logic [1:0]  addr_sel = 2'b00;
   logic [31:0] status = 32'hD4C3B2A1;
   logic        sda_oe, standby, proc_rst, busy;
   logic [63:0] cfg;
   logic        sda_line;

   int checks = 0;
   int fails  = 0;
   int busy_tot = 0;
   int rst_tot  = 0;
   bit done = 1'b0;
   logic [7:0] m [8];

   assign sda_line = !(sda_low || sda_oe);

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_regbank_i2c uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .status_i(status),
      .cfg_o(cfg), .standby_o(standby), .proc_rst_o(proc_rst),
      .preset_busy_o(busy));

   always @(posedge clk) begin
      if (busy)     busy_tot++;
      if (proc_rst) rst_tot++;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] packm();
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[8*i +: 8] = m[i];
      return r;
   endfunction

   function automatic logic [7:0] pre(input int s, input int k);
      return 8'(s*16 + 2*k + 1);
   endfunction

   task automatic bus_start();
      sda_low = 1'b0; tick(Q);
      scl = 1'b1;     tick(Q);
      sda_low = 1'b1; tick(Q);
      scl = 1'b0;     tick(Q);
   endtask

   task automatic bus_stop();
      sda_low = 1'b1; tick(Q);
      scl = 1'b1;     tick(Q);
      sda_low = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_low = !b[i]; tick(Q);
         scl = 1'b1;      tick(Q);
         scl = 1'b0;      tick(Q);
      end
      sda_low = 1'b0; tick(Q);
      scl = 1'b1;     tick(Q/2);
      ack = !sda_line; tick(Q/2);
      scl = 1'b0;     tick(Q);
   endtask

   task automatic recv_byte(input logic last, output logic [7:0] b);
      sda_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl = 1'b1; tick(Q/2);
         b[i] = sda_line; tick(Q/2);
         scl = 1'b0;
      end
      sda_low = !last; tick(Q);
      scl = 1'b1;      tick(Q);
      scl = 1'b0;      tick(Q);
      sda_low = 1'b0;
   endtask

   task automatic xfer_write(input logic [6:0] a, input logic [7:0] idx,
                             input logic [7:0] d [4], input int n, output logic acked);
      logic ack;
      bus_start();
      send_byte({a, 1'b0}, ack);
      acked = ack;
      if (ack) begin
         send_byte(idx, ack);
         for (int i = 0; i < n; i++) send_byte(d[i], ack);
      end
      bus_stop();
      tick(16);
   endtask

   task automatic xfer_read(input logic [6:0] a, input logic [7:0] idx,
                            input int n, output logic [7:0] d [4]);
      logic ack;
      bus_start();
      send_byte({a, 1'b0}, ack);
      send_byte(idx, ack);
      bus_start();
      send_byte({a, 1'b1}, ack);
      for (int i = 0; i < n; i++) recv_byte(i == n - 1, d[i]);
      bus_stop();
      tick(16);
   endtask

   task automatic wr1(input logic [7:0] idx, input logic [7:0] v);
      logic [7:0] d [4];
      logic ack;
      d[0] = v; d[1] = 8'h0; d[2] = 8'h0; d[3] = 8'h0;
      xfer_write(7'h42, idx, d, 1, ack);
   endtask

   task automatic t_reset();
      m[0] = 8'h01;
      for (int k = 0; k < 6; k++) m[k+1] = pre(0, k);
      m[7] = 8'h01;
      chk("R10", "cfg after reset", cfg, packm());
      chk("R4", "selector default", {56'b0, cfg[7:0]}, 64'h01);
      chk("R9", "standby after reset", {63'b0, standby}, 64'd0);
      chk("R8", "no reset pulse after reset", {63'b0, proc_rst}, 64'd0);
      chk("R1", "line released after reset", {63'b0, sda_oe}, 64'd0);
   endtask

   task automatic t_read_basic();
      logic [7:0] d [4];
      xfer_read(7'h42, 8'h00, 4, d);
      chk("R3", "read 00h", {56'b0, d[0]}, 64'h01);
      chk("R3", "read 01h", {56'b0, d[1]}, 64'h01);
      chk("R3", "read 02h", {56'b0, d[2]}, 64'h03);
      chk("R3", "read 03h", {56'b0, d[3]}, 64'h05);
      xfer_read(7'h42, 8'h0C, 2, d);
      chk("R7", "identity", {56'b0, d[0]}, 64'h5C);
      chk("R7", "index past identity", {56'b0, d[1]}, 64'h00);
      xfer_read(7'h42, 8'h08, 4, d);
      chk("R7", "status bytes", {32'b0, d[3], d[2], d[1], d[0]}, {32'b0, status});
   endtask

   task automatic t_easy();
      int b0;
      logic [7:0] d [4];
      b0 = busy_tot;
      wr1(8'h00, 8'h10);
      chk("R5", "busy cycles", 64'(busy_tot - b0), 64'd6);
      m[0] = 8'h10;
      for (int k = 0; k < 6; k++) m[k+1] = pre(4, k);
      chk("R5", "cfg after D/K preset", cfg, packm());
      xfer_read(7'h42, 8'h01, 2, d);
      chk("R5", "preset read back", {48'b0, d[1], d[0]}, {48'b0, pre(4, 1), pre(4, 0)});
      wr1(8'h00, 8'h80);
      m[0] = 8'h80;
      for (int k = 0; k < 6; k++) m[k+1] = pre(7, k);
      chk("R5", "cfg after FM preset", cfg, packm());
   endtask

   task automatic t_bad_hot();
      int b0;
      b0 = busy_tot;
      wr1(8'h00, 8'h06);
      m[0] = 8'h06;
      chk("R6", "two-bit value stored, no load", cfg, packm());
      wr1(8'h00, 8'h00);
      m[0] = 8'h00;
      chk("R6", "zero value stored, no load", cfg, packm());
      chk("R6", "no busy cycles", 64'(busy_tot - b0), 64'd0);
   endtask

   task automatic t_burst();
      logic [7:0] d [4];
      logic ack;
      d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h00;
      xfer_write(7'h42, 8'h02, d, 3, ack);
      m[2] = 8'h11; m[3] = 8'h22; m[4] = 8'h33;
      chk("R2", "burst write", cfg, packm());
   endtask

   task automatic t_readonly();
      logic [7:0] d [4];
      logic ack;
      d[0] = 8'h55; d[1] = 8'h66; d[2] = 8'h77; d[3] = 8'h00;
      xfer_write(7'h42, 8'h0A, d, 3, ack);
      xfer_read(7'h42, 8'h0A, 3, d);
      chk("R7", "status ignores writes", {40'b0, d[2], d[1], d[0]},
          {40'b0, 8'h5C, status[31:16]});
      chk("R7", "cfg untouched", cfg, packm());
   endtask

   task automatic t_addr();
      logic [7:0] d [4];
      logic ack;
      d[0] = 8'hEE; d[1] = 8'h0; d[2] = 8'h0; d[3] = 8'h0;
      xfer_write(7'h43, 8'h01, d, 1, ack);
      chk("R1", "foreign address nack", {63'b0, ack}, 64'd0);
      chk("R1", "foreign write ignored", cfg, packm());
      addr_sel = 2'b01;
      tick(4);
      xfer_write(7'h42, 8'h01, d, 1, ack);
      chk("R1", "old address nack after select", {63'b0, ack}, 64'd0);
      xfer_write(7'h40, 8'h01, d, 1, ack);
      m[1] = 8'hEE;
      chk("R1", "selected address ack", {63'b0, ack}, 64'd1);
      chk("R1", "selected address write", cfg, packm());
      addr_sel = 2'b00;
      tick(4);
   endtask

   task automatic t_ctrl();
      int r0;
      logic [7:0] d [4];
      r0 = rst_tot;
      wr1(8'h07, 8'h03);
      chk("R9", "standby set", {63'b0, standby}, 64'd1);
      chk("R8", "no pulse when bit0 high", 64'(rst_tot - r0), 64'd0);
      xfer_read(7'h42, 8'h07, 1, d);
      chk("R9", "control read", {56'b0, d[0]}, 64'h03);
      r0 = rst_tot;
      wr1(8'h07, 8'h00);
      chk("R8", "pulse length", 64'(rst_tot - r0), 64'd4);
      chk("R9", "standby cleared", {63'b0, standby}, 64'd0);
      xfer_read(7'h42, 8'h07, 1, d);
      chk("R8", "bit0 restores", {56'b0, d[0]}, 64'h01);
      m[7] = 8'h01;
      chk("R8", "registers kept", cfg, packm());
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      t_reset();
      t_read_basic();
      t_easy();
      t_bad_hot();
      t_burst();
      t_readonly();
      t_addr();
      t_ctrl();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule